// File: doc/BRIEF.md
# Peripheral Power Mode Controller

This block decides which power state a peripheral logic block is in: full power, doze or nap. In full power every gated unit receives its clock enable. In doze and nap those enables drop, and a keep-alive enable stays high. The keep-alive enable powers the units that must keep running: PCI address decoding, the PCI arbiter, memory refresh, processor bus request monitoring, NMI monitoring, the interrupt controller and the two-wire serial unit.

Software sets three control bits: a master power-management enable, a doze enable and a nap enable. Doze is entered whenever the master and doze enables are set and no work is pending. Doze does not depend on the processor core's power state. Nap additionally requires the core to report that it is ready to nap or sleep. While in nap, a quiesce acknowledge output is driven high.

Any of several wake events brings the block back to full power through a fixed-latency ramp:
- a PCI access to system memory,
- a processor bus request,
- an interrupt controller output,
- NMI, but only when a machine-check enable is set.

After a wake has been serviced, the block drops back to doze on its own. It stays in full power if the enables were cleared or work is still pending. A synchronous hard reset request forces full power on the next edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, and after any later `rst_n` assertion, the block is in full power: `pm_state`=0, `unit_clk_en` all ones, `keep_alive_en`=0, `quiesce_ack`=0.
- R2: From full power the block enters doze (`pm_state`=1) on the next edge when all of these hold: `pm_en`=1, `doze_en`=1, `ops_pending`=0, the busy flag is clear, no wake event is present, and the nap condition does not hold. `core_nap_rdy` plays no part in this.
- R3: While `pm_state` is not 0, `unit_clk_en` is all zeros and `keep_alive_en` is 1. In full power `keep_alive_en` is 0.
- R4: In doze or nap, any of `wk_pci_mem`, `wk_cpu_req` or `wk_pic_int` moves the block to the wake ramp (`pm_state`=3) on the next edge. `wk_nmi` does the same only while `mchk_en`=1; with `mchk_en`=0 it has no effect and the block stays in doze.
- R5: `unit_clk_en` returns to all ones exactly WAKE_LAT edges after the edge that samples the wake event, counting that edge. `pm_state` reads 3 in between.
- R6: A wake from doze or nap sets a busy flag. Doze is not re-entered until an edge in full power has sampled `ops_pending`=0, which clears the flag. Doze then follows on the next edge if the enables are still set.
- R7: If `pm_en` or `doze_en` is clear after a wake, the block stays in full power.
- R8: Nap (`pm_state`=2) is entered from full power only when `pm_en`, `nap_en` and `core_nap_rdy` are all 1. `quiesce_ack` is 1 while in nap.
- R9: When both the nap and the doze conditions hold in full power, nap is chosen.
- R10: On a wake from nap, `quiesce_ack` stays 1 through the wake ramp. It falls in the same cycle that `unit_clk_en` returns to all ones.
- R11: `hard_rst`=1 forces full power on the next edge from any state, including mid-ramp, and clears the busy flag.
- R12: Clearing the enable of the current low-power state (`pm_en` or `doze_en` in doze, `pm_en` or `nap_en` in nap) leaves through the wake ramp without setting the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_en | input | 1 | Master power-management enable |
| doze_en | input | 1 | Doze enable |
| nap_en | input | 1 | Nap enable |
| mchk_en | input | 1 | Lets NMI act as a wake event |
| ops_pending | input | 1 | Work outstanding for the peripheral logic |
| core_nap_rdy | input | 1 | Core ready to nap or sleep |
| wk_pci_mem | input | 1 | PCI access to system memory |
| wk_cpu_req | input | 1 | Processor bus request |
| wk_nmi | input | 1 | Non-maskable interrupt |
| wk_pic_int | input | 1 | Interrupt controller output |
| hard_rst | input | 1 | Synchronous hard reset request |
| unit_clk_en | output | NUM_UNITS | Clock enables of the gated units |
| keep_alive_en | output | 1 | Enable of the always-on units' low-power path |
| quiesce_ack | output | 1 | Nap acknowledge |
| pm_state | output | 2 | Current state: 0 full, 1 doze, 2 nap, 3 wake ramp |

## Verification
The enable bits are driven in several combinations against the same doze and nap conditions:
- Master enable cleared, which tells a correct gate from a single-bit one.
- Doze alone, with the core ready flag low.
- Both low-power enables together with the core ready, which shows the nap priority.

Each of the four wake sources is applied on its own. NMI is applied both with and without its qualifier, so a missing qualifier shows up as a spurious wake. The wake pulses are sampled cycle by cycle through the ramp, so an off-by-one in the latency counter or a misplaced acknowledge drop is visible. Pending-work and hard-reset patterns arrive at different points after a wake, which separates the busy-flag hold-off from the plain doze entry.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      PM_FULL = 2'd0,
      PM_DOZE = 2'd1,
      PM_NAP  = 2'd2,
      PM_WAKE = 2'd3
   } pm_state_t;

   // index of each wake source inside the source vector
   localparam int unsigned SRC_PCI  = 0;
   localparam int unsigned SRC_CPU  = 1;
   localparam int unsigned SRC_NMI  = 2;
   localparam int unsigned SRC_PIC  = 3;
   localparam int unsigned NUM_SRC  = 4;

   function automatic logic is_low_power(pm_state_t s);
      return (s == PM_DOZE) || (s == PM_NAP);
   endfunction

endpackage

// File: rtl/pm_wake_qual.sv
module pm_wake_qual #(
   parameter int unsigned        NSRC      = 4,
   parameter logic [NSRC-1:0]    QUAL_MASK = 4'b0100
) (
   input  logic [NSRC-1:0] src,
   input  logic            qual_en,
   output logic            wake_any
);
   initial begin
      if (NSRC < 1) $error("pm_wake_qual: NSRC must be at least 1");
   end

   logic [NSRC-1:0] gated;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         if (QUAL_MASK[gi]) begin : g_qual
            assign gated[gi] = src[gi] & qual_en;
         end else begin : g_plain
            assign gated[gi] = src[gi];
         end
      end
   endgenerate

   assign wake_any = |gated;

endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
   parameter int unsigned WAKE_LAT = 4,
   localparam int unsigned CW      = $clog2(WAKE_LAT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   output logic done
);
   initial begin
      if (WAKE_LAT < 2) $error("pm_wake_timer: WAKE_LAT must be at least 2");
   end

   localparam logic [CW-1:0] LAST = CW'(WAKE_LAT - 1);

   logic [CW-1:0] cnt;

   assign done = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CW'(1);
      end else if (done) begin
         cnt <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt + CW'(1);
      end
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R5
   cnt_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !done && !clr && !start) |=> cnt == $past(cnt) + CW'(1));

endmodule

// File: rtl/pm_gate_out.sv
module pm_gate_out
   import pwr_mode_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pm_state_t            state,
   input  logic                 from_nap,
   output logic [NUM_UNITS-1:0] unit_clk_en,
   output logic                 keep_alive_en,
   output logic                 quiesce_ack
);
   initial begin
      if (NUM_UNITS < 1) $error("pm_gate_out: NUM_UNITS must be at least 1");
   end

   logic full_on;
   assign full_on = (state == PM_FULL);

   genvar ui;
   generate
      for (ui = 0; ui < NUM_UNITS; ui++) begin : g_unit
         assign unit_clk_en[ui] = full_on;
      end
   endgenerate

   assign keep_alive_en = !full_on;
   assign quiesce_ack   = (state == PM_NAP) || (state == PM_WAKE && from_nap);

   // R3
   ka_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keep_alive_en |-> (unit_clk_en == '0));

   // R10
   qack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(quiesce_ack) |-> (&unit_clk_en));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 8,
   parameter int unsigned WAKE_LAT  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pm_en,
   input  logic                 doze_en,
   input  logic                 nap_en,
   input  logic                 mchk_en,
   input  logic                 ops_pending,
   input  logic                 core_nap_rdy,
   input  logic                 wk_pci_mem,
   input  logic                 wk_cpu_req,
   input  logic                 wk_nmi,
   input  logic                 wk_pic_int,
   input  logic                 hard_rst,
   output logic [NUM_UNITS-1:0] unit_clk_en,
   output logic                 keep_alive_en,
   output logic                 quiesce_ack,
   output logic [1:0]           pm_state
);
   initial begin
      if (WAKE_LAT < 2)  $error("pwr_mode_ctrl: WAKE_LAT must be at least 2");
      if (NUM_UNITS < 1) $error("pwr_mode_ctrl: NUM_UNITS must be at least 1");
   end

   localparam logic [NUM_SRC-1:0] NMI_MASK = NUM_SRC'(1) << SRC_NMI;

   pm_state_t st_q, st_d;
   logic      busy_q, busy_d;
   logic      nap_src_q, nap_src_d;
   logic      wake_any, tmr_start, tmr_done;
   logic      nap_go, doze_go;
   logic [NUM_SRC-1:0] srcs;

   assign srcs[SRC_PCI] = wk_pci_mem;
   assign srcs[SRC_CPU] = wk_cpu_req;
   assign srcs[SRC_NMI] = wk_nmi;
   assign srcs[SRC_PIC] = wk_pic_int;

   pm_wake_qual #(.NSRC(NUM_SRC), .QUAL_MASK(NMI_MASK)) u_qual (
      .src      (srcs),
      .qual_en  (mchk_en),
      .wake_any (wake_any)
   );

   assign nap_go  = pm_en && nap_en && core_nap_rdy;
   assign doze_go = pm_en && doze_en && !ops_pending;

   always_comb begin
      st_d      = st_q;
      busy_d    = busy_q;
      nap_src_d = nap_src_q;
      tmr_start = 1'b0;
      if (hard_rst) begin
         st_d      = PM_FULL;
         busy_d    = 1'b0;
         nap_src_d = 1'b0;
      end else begin
         unique case (st_q)
            PM_FULL: begin
               if (busy_q && !ops_pending) busy_d = 1'b0;
               if (!busy_q && !wake_any) begin
                  if (nap_go) begin
                     st_d = PM_NAP;
                  end else if (doze_go) begin
                     st_d = PM_DOZE;
                  end
               end
            end
            PM_DOZE: begin
               if (wake_any || !(pm_en && doze_en)) begin
                  st_d      = PM_WAKE;
                  tmr_start = 1'b1;
                  nap_src_d = 1'b0;
                  busy_d    = wake_any;
               end
            end
            PM_NAP: begin
               if (wake_any || !(pm_en && nap_en)) begin
                  st_d      = PM_WAKE;
                  tmr_start = 1'b1;
                  nap_src_d = 1'b1;
                  busy_d    = wake_any;
               end
            end
            PM_WAKE: begin
               if (tmr_done) begin
                  st_d      = PM_FULL;
                  nap_src_d = 1'b0;
               end
            end
            default: st_d = PM_FULL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PM_FULL;
         busy_q    <= 1'b0;
         nap_src_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         busy_q    <= busy_d;
         nap_src_q <= nap_src_d;
      end
   end

   pm_wake_timer #(.WAKE_LAT(WAKE_LAT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hard_rst),
      .start (tmr_start),
      .done  (tmr_done)
   );

   pm_gate_out #(.NUM_UNITS(NUM_UNITS)) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (st_q),
      .from_nap      (nap_src_q),
      .unit_clk_en   (unit_clk_en),
      .keep_alive_en (keep_alive_en),
      .quiesce_ack   (quiesce_ack)
   );

   assign pm_state = st_q;

   // R11
   hrst_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst |=> (pm_state == 2'd0));

   // R2
   doze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 2'd1 && $past(pm_state) == 2'd0) |->
         $past(pm_en && doze_en && !ops_pending));

   // R8
   nap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 2'd2 && $past(pm_state) != 2'd2) |->
         $past(pm_en && nap_en && core_nap_rdy));

   // R4
   doze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 2'd1 && pm_en && doze_en && !hard_rst && !wk_pci_mem &&
       !wk_cpu_req && !wk_pic_int && !(wk_nmi && mchk_en)) |=> (pm_state == 2'd1));

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NU         = 8;
   localparam int LAT        = 4;
   localparam int WDOG_LIMIT = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pm_en = 0, doze_en = 0, nap_en = 0, mchk_en = 0;
   logic ops_pending = 0, core_nap_rdy = 0, hard_rst = 0;
   logic wk_pci_mem = 0, wk_cpu_req = 0, wk_nmi = 0, wk_pic_int = 0;
   logic [NU-1:0] unit_clk_en;
   logic keep_alive_en, quiesce_ack;
   logic [1:0] pm_state;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.NUM_UNITS(NU), .WAKE_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .pm_en(pm_en), .doze_en(doze_en), .nap_en(nap_en),
      .mchk_en(mchk_en), .ops_pending(ops_pending), .core_nap_rdy(core_nap_rdy),
      .wk_pci_mem(wk_pci_mem), .wk_cpu_req(wk_cpu_req), .wk_nmi(wk_nmi),
      .wk_pic_int(wk_pic_int), .hard_rst(hard_rst), .unit_clk_en(unit_clk_en),
      .keep_alive_en(keep_alive_en), .quiesce_ack(quiesce_ack), .pm_state(pm_state)
   );

   typedef struct packed {
      logic [3:0] ctl;   // pm, doze, nap, mchk
      logic       ops;
      logic       rdy;
      logic [3:0] wk;    // pci, cpu, nmi, pic
      logic       hrst;
      logic [2:0] cyc;   // edges to advance
      logic [1:0] st;    // expected pm_state
      logic       q;     // expected quiesce_ack
      logic [3:0] req;   // requirement number for messages
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd1,1'b0,4'd2},   // R2 doze, core not ready
      '{4'b1100,1'b0,1'b0,4'b0010,1'b0,3'd1,2'd1,1'b0,4'd4},   // R4 NMI without qualifier ignored
      '{4'b1101,1'b0,1'b0,4'b0010,1'b0,3'd1,2'd3,1'b0,4'd4},   // R4 NMI qualified wakes
      '{4'b1101,1'b1,1'b0,4'b0000,1'b0,3'd2,2'd3,1'b0,4'd5},   // R5 ramp
      '{4'b1101,1'b1,1'b0,4'b0000,1'b0,3'd1,2'd0,1'b0,4'd5},   // R5 full after LAT edges
      '{4'b1101,1'b1,1'b0,4'b0000,1'b0,3'd3,2'd0,1'b0,4'd6},   // R6 pending holds full
      '{4'b1101,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd0,1'b0,4'd6},   // R6 busy clears
      '{4'b1101,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd1,1'b0,4'd6},   // R6 back to doze
      '{4'b1100,1'b0,1'b0,4'b1000,1'b0,3'd1,2'd3,1'b0,4'd4},   // R4 PCI wake
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd3,2'd0,1'b0,4'd5},   // R5
      '{4'b0100,1'b0,1'b0,4'b0000,1'b0,3'd3,2'd0,1'b0,4'd7},   // R7 master cleared
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd2,2'd1,1'b0,4'd2},   // R2
      '{4'b1100,1'b0,1'b0,4'b0100,1'b0,3'd4,2'd0,1'b0,4'd4},   // R4 CPU wake, full by LAT
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd2,2'd1,1'b0,4'd6},   // R6
      '{4'b1100,1'b0,1'b0,4'b0001,1'b0,3'd1,2'd3,1'b0,4'd4},   // R4 interrupt wake
      '{4'b1010,1'b0,1'b1,4'b0000,1'b0,3'd3,2'd0,1'b0,4'd5},   // R5
      '{4'b1010,1'b0,1'b1,4'b0000,1'b0,3'd1,2'd0,1'b0,4'd6},   // R6 busy clears
      '{4'b1010,1'b0,1'b1,4'b0000,1'b0,3'd1,2'd2,1'b1,4'd8},   // R8 nap with ack
      '{4'b1010,1'b0,1'b1,4'b1000,1'b0,3'd1,2'd3,1'b1,4'd10},  // R10 ack held in ramp
      '{4'b1010,1'b0,1'b1,4'b0000,1'b0,3'd2,2'd3,1'b1,4'd10},  // R10
      '{4'b1010,1'b0,1'b1,4'b0000,1'b0,3'd1,2'd0,1'b0,4'd10},  // R10 ack drops with clocks
      '{4'b1110,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd0,1'b0,4'd6},   // R6
      '{4'b1110,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd1,1'b0,4'd8},   // R8 no ready, no nap
      '{4'b1110,1'b0,1'b1,4'b0000,1'b1,3'd1,2'd0,1'b0,4'd11},  // R11 hard reset from doze
      '{4'b1110,1'b0,1'b1,4'b0000,1'b0,3'd1,2'd2,1'b1,4'd9},   // R9 nap priority
      '{4'b1100,1'b0,1'b1,4'b0000,1'b0,3'd1,2'd3,1'b1,4'd12},  // R12 nap enable cleared
      '{4'b1100,1'b0,1'b1,4'b0000,1'b0,3'd3,2'd0,1'b0,4'd12},  // R12
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd1,1'b0,4'd12},  // R12 no busy hold-off
      '{4'b1100,1'b0,1'b0,4'b0000,1'b1,3'd1,2'd0,1'b0,4'd11},  // R11
      '{4'b1100,1'b0,1'b0,4'b0000,1'b0,3'd1,2'd1,1'b0,4'd11},  // R11 busy cleared
      '{4'b1100,1'b0,1'b0,4'b1000,1'b0,3'd1,2'd3,1'b0,4'd4},   // R4
      '{4'b1100,1'b0,1'b0,4'b0000,1'b1,3'd1,2'd0,1'b0,4'd11}   // R11 mid-ramp
   };

   task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %0h expected %0h", rq, got, exp);
      end
   endtask

   task automatic chk_outs(input int r, input logic [1:0] st, input logic q);
      string rq;
      rq = $sformatf("R%0d", r);
      chk({rq, " state"}, 32'(pm_state), 32'(st));
      chk({rq, " clk_en (R3)"}, 32'(unit_clk_en), (st == 2'd0) ? 32'((1 << NU) - 1) : 32'd0);
      chk({rq, " keep_alive (R3)"}, 32'(keep_alive_en), 32'(st != 2'd0));
      chk({rq, " qack"}, 32'(quiesce_ack), 32'(q));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_cnt++;
         if (cyc_cnt > WDOG_LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog got %0d expected <= %0d", cyc_cnt, WDOG_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_outs(1, 2'd0, 1'b0);   // R1 reset state

      for (int i = 0; i < NV; i++) begin
         {pm_en, doze_en, nap_en, mchk_en} = VEC[i].ctl;
         ops_pending  = VEC[i].ops;
         core_nap_rdy = VEC[i].rdy;
         {wk_pci_mem, wk_cpu_req, wk_nmi, wk_pic_int} = VEC[i].wk;
         hard_rst     = VEC[i].hrst;
         for (int c = 0; c < int'(VEC[i].cyc); c++) @(negedge clk);
         chk_outs(int'(VEC[i].req), VEC[i].st, VEC[i].q);
      end

      // R5 directed: sample every cycle of the ramp from doze
      hard_rst = 0; {wk_pci_mem, wk_cpu_req, wk_nmi, wk_pic_int} = 4'b0000;
      {pm_en, doze_en, nap_en, mchk_en} = 4'b1100;
      ops_pending = 0; core_nap_rdy = 0;
      @(negedge clk);
      chk_outs(5, 2'd1, 1'b0);
      wk_pic_int = 1'b1;
      @(negedge clk);
      wk_pic_int = 1'b0;
      for (int k = 1; k < LAT; k++) begin
         chk_outs(5, 2'd3, 1'b0);
         @(negedge clk);
      end
      chk_outs(5, 2'd0, 1'b0);

      // R1 directed: asynchronous reset from doze
      repeat (3) @(negedge clk);
      chk_outs(1, 2'd1, 1'b0);
      rst_n = 1'b0;
      #1;
      chk_outs(1, 2'd0, 1'b0);
      {pm_en, doze_en} = 2'b00;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_outs(1, 2'd0, 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule